// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider Channel

This block divides a fast input clock down for one output channel. The time spent high and the time spent low are programmed independently, each as a count of input clock cycles minus one. This gives any duty cycle that the count width allows. A chip-level synchronization request lines up several channels. While the request is held, the channel waits at a programmable starting level. After release it waits a programmable number of extra input cycles before it starts counting, which shifts the phase of its waveform.

Three further controls set the output. A bypass control routes the input clock straight to the output and freezes the divider state. An ignore-synchronization control detaches the channel from the request and drives the output to a programmable static level. While the channel is detached, its counter keeps running in the background. Changes to the high or low counts are taken up only at the next phase boundary, so a reprogrammed channel never emits a shortened pulse.

Top module: `clkdiv_chan`

## Requirements
- R1: After reset the output is low, and with both counts at the default of 7 the first low phase lasts 8 input cycles.
- R2: With low count L (0 to 15), every low phase of the free-running output lasts L+1 input cycles; L=0 gives a single-cycle low phase.
- R3: With high count H (0 to 15), every high phase of the free-running output lasts H+1 input cycles; H=0 gives a single-cycle high phase.
- R4: While the sync request is high, ignore-sync is 0 and bypass is 0, the output sits at the starting level and does not toggle.
- R5: After the last input edge that sees the sync request high, the starting level lasts offset + N + 1 input cycles, where N is the count for that level.
- R6: A start-level bit of 1 makes the channel begin in the high phase after synchronization, and 0 makes it begin in the low phase.
- R7: A change to the high or low count during a phase does not alter that phase. The new value applies from the next phase of that level onward.
- R8: While ignore-sync is 1, sync pulses do not disturb the counter. After ignore-sync returns to 0, the waveform continues as if no pulse had occurred.
- R9: While ignore-sync is 1 and bypass is 0, the output equals the force bit (1 = high, 0 = low).
- R10: While bypass is 1, the output equals the input clock and the divider state is frozen. After bypass clears, the divider resumes from where it stopped.
- R11: While ignore-sync is 0, the force bit has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Chip-level synchronization request, active high |
| cfg_lo_i | input | CNT_W | Low-phase length minus one |
| cfg_hi_i | input | CNT_W | High-phase length minus one |
| cfg_ofs_i | input | OFS_W | Extra input cycles of waiting after sync release |
| cfg_start_hi_i | input | 1 | Starting level after synchronization (1 = high) |
| cfg_ign_sync_i | input | 1 | Detach from sync request and drive the static level |
| cfg_force_hi_i | input | 1 | Static level used while detached (1 = high) |
| cfg_bypass_i | input | 1 | Route the input clock to the output, freeze the divider |
| clk_o | output | 1 | Divided clock output |

## Verification
The bench builds the block with its defaults: 4-bit counts, a 4-bit offset, offset support enabled and reset lengths of 7. This puts every count and offset value, including the single-cycle phases at 0 and the longest phases at 15, within reach of the random settings. A behavioural model predicts the level and the cycles left in the phase on every clock. Against this model the bench checks period, duty cycle and phase after sync release. It also checks count changes made in the middle of a phase, sync pulses that arrive while the channel is detached, and freeze and resume around bypass.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic {
      PH_LO = 1'b0,
      PH_HI = 1'b1
   } phase_e;

   function automatic phase_e flip_phase(input phase_e p);
      return (p == PH_HI) ? PH_LO : PH_HI;
   endfunction

endpackage

// File: rtl/clkdiv_sync_gate.sv
module clkdiv_sync_gate #(
   parameter int unsigned OFS_W      = 4,
   parameter bit          HAS_OFFSET = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   input  logic             ign_i,
   input  logic             byp_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic             load_o,
   output logic             run_o
);

   logic sync_eff;
   assign sync_eff = sync_i & ~ign_i;
   assign load_o   = ~byp_i & sync_eff;

   generate
      if (HAS_OFFSET) begin : g_offset
         logic [OFS_W-1:0] dly_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               dly_q <= '0;
            end else if (!byp_i) begin
               if (sync_eff) begin
                  dly_q <= ofs_i;
               end else if (dly_q != '0) begin
                  dly_q <= dly_q - 1'b1;
               end
            end
         end

         assign run_o = ~byp_i & ~sync_eff & (dly_q == '0);
      end else begin : g_no_offset
         logic unused_ofs;
         assign unused_ofs = ^ofs_i;
         assign run_o      = ~byp_i & ~sync_eff;
      end
   endgenerate

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt
   import clkdiv_pkg::*;
#(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned DEF_LO = 7,
   parameter int unsigned DEF_HI = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             run_i,
   input  logic             start_hi_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic [CNT_W-1:0] hi_i,
   output logic             ph_o
);

   localparam logic [CNT_W-1:0] RST_LO = CNT_W'(DEF_LO);
   localparam logic [CNT_W-1:0] RST_HI = CNT_W'(DEF_HI);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_lo_q;
   logic [CNT_W-1:0] len_hi_q;
   logic [CNT_W-1:0] cur_len;
   logic             at_end;

   assign cur_len = (ph_q == PH_HI) ? len_hi_q : len_lo_q;
   assign at_end  = (cnt_q == cur_len);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q     <= PH_LO;
         cnt_q    <= '0;
         len_lo_q <= RST_LO;
         len_hi_q <= RST_HI;
      end else if (load_i) begin
         ph_q     <= start_hi_i ? PH_HI : PH_LO;
         cnt_q    <= '0;
         len_lo_q <= lo_i;
         len_hi_q <= hi_i;
      end else if (run_i) begin
         if (at_end) begin
            ph_q     <= flip_phase(ph_q);
            cnt_q    <= '0;
            len_lo_q <= lo_i;
            len_hi_q <= hi_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign ph_o = (ph_q == PH_HI);

endmodule

// File: rtl/clkdiv_out_sel.sv
module clkdiv_out_sel (
   input  logic clk_i,
   input  logic ph_i,
   input  logic ign_i,
   input  logic force_hi_i,
   input  logic byp_i,
   output logic clk_o
);

   logic div_lvl;

   always_comb begin
      div_lvl = ign_i ? force_hi_i : ph_i;
      clk_o   = byp_i ? clk_i : div_lvl;
   end

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned OFS_W      = 4,
   parameter bit          HAS_OFFSET = 1'b1,
   parameter int unsigned DEF_LO     = 7,
   parameter int unsigned DEF_HI     = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sync_i,
   input  logic [CNT_W-1:0] cfg_lo_i,
   input  logic [CNT_W-1:0] cfg_hi_i,
   input  logic [OFS_W-1:0] cfg_ofs_i,
   input  logic             cfg_start_hi_i,
   input  logic             cfg_ign_sync_i,
   input  logic             cfg_force_hi_i,
   input  logic             cfg_bypass_i,
   output logic             clk_o
);

   localparam int unsigned MAX_LEN = 1 << CNT_W;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("clkdiv_chan: CNT_W must lie in 1..16");
      end
      if (OFS_W < 1 || OFS_W > 16) begin : g_bad_ofs_w
         $error("clkdiv_chan: OFS_W must lie in 1..16");
      end
      if (DEF_LO >= MAX_LEN || DEF_HI >= MAX_LEN) begin : g_bad_def
         $error("clkdiv_chan: reset lengths must fit in CNT_W bits");
      end
   endgenerate

   logic load;
   logic run;
   logic ph_q;

   clkdiv_sync_gate #(
      .OFS_W      (OFS_W),
      .HAS_OFFSET (HAS_OFFSET)
   ) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_i),
      .ign_i  (cfg_ign_sync_i),
      .byp_i  (cfg_bypass_i),
      .ofs_i  (cfg_ofs_i),
      .load_o (load),
      .run_o  (run)
   );

   clkdiv_phase_cnt #(
      .CNT_W  (CNT_W),
      .DEF_LO (DEF_LO),
      .DEF_HI (DEF_HI)
   ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .run_i      (run),
      .start_hi_i (cfg_start_hi_i),
      .lo_i       (cfg_lo_i),
      .hi_i       (cfg_hi_i),
      .ph_o       (ph_q)
   );

   clkdiv_out_sel u_out (
      .clk_i      (clk_i),
      .ph_i       (ph_q),
      .ign_i      (cfg_ign_sync_i),
      .force_hi_i (cfg_force_hi_i),
      .byp_i      (cfg_bypass_i),
      .clk_o      (clk_o)
   );

endmodule

// File: rtl/clkdiv_chan_chk.sv
module clkdiv_chan_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic sync_i,
   input logic ign_i,
   input logic byp_i,
   input logic force_hi_i,
   input logic start_hi_i,
   input logic ph_i,
   input logic clk_o
);

   AST_SYNC_HOLD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_i && !ign_i && !byp_i) |=> (ph_i == $past(start_hi_i))) else $error("sync hold level"); // R4

   AST_BYPASS_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byp_i |=> $stable(ph_i)) else $error("bypass freeze"); // R10

   AST_FORCE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ign_i && !byp_i) |-> (clk_o == force_hi_i)) else $error("force level"); // R9

   AST_DIVIDED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ign_i && !byp_i) |-> (clk_o == ph_i)) else $error("divided pass"); // R11

endmodule

bind clkdiv_chan clkdiv_chan_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sync_i     (sync_i),
   .ign_i      (cfg_ign_sync_i),
   .byp_i      (cfg_bypass_i),
   .force_hi_i (cfg_force_hi_i),
   .start_hi_i (cfg_start_hi_i),
   .ph_i       (ph_q),
   .clk_o      (clk_o)
);

// File: tb/clkdiv_chan_tb.sv
`timescale 1ns/1ps
module clkdiv_chan_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync = 1'b0;
   logic [3:0] lo = 4'd7;
   logic [3:0] hi = 4'd7;
   logic [3:0] ofs = 4'd0;
   logic       start_hi = 1'b0;
   logic       ign = 1'b0;
   logic       force_hi = 1'b0;
   logic       byp = 1'b0;
   logic       clk_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   // behavioural reference: current level and input edges left in it
   bit m_lvl = 1'b0;
   int m_left = 8;

   always #2 clk = ~clk;

   clkdiv_chan u_dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .sync_i         (sync),
      .cfg_lo_i       (lo),
      .cfg_hi_i       (hi),
      .cfg_ofs_i      (ofs),
      .cfg_start_hi_i (start_hi),
      .cfg_ign_sync_i (ign),
      .cfg_force_hi_i (force_hi),
      .cfg_bypass_i   (byp),
      .clk_o          (clk_out)
   );

   task automatic check(input bit exp, input string what);
      checks++;
      if (clk_out !== exp) begin
         errors++;
         $display("FAIL %s %s: clk_o=%b expected=%b at %0t", tag, what, clk_out, exp, $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_lvl = 1'b0; m_left = 8;
      end else if (!byp) begin
         if (sync && !ign) begin
            m_lvl  = start_hi;
            m_left = int'(ofs) + (start_hi ? int'(hi) : int'(lo)) + 1;
         end else begin
            m_left--;
            if (m_left == 0) begin
               m_lvl  = ~m_lvl;
               m_left = (m_lvl ? int'(hi) : int'(lo)) + 1;
            end
         end
      end
   endtask

   // one input cycle: reference update at the edge, compare away from it
   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         #1;
         if (byp) check(1'b1, "bypass high half");
         @(negedge clk);
         #0.5;
         check(byp ? 1'b0 : (ign ? force_hi : m_lvl), "cycle compare");
      end
   endtask

   task automatic do_sync(input int len);
      sync = 1'b1;
      step(len);
      sync = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      tag = "R1";
      check(1'b0, "reset level");
      step(20);

      // random periods, duty cycles, offsets and start levels
      for (int k = 0; k < 12; k++) begin
         lo = 4'($urandom_range(0, 15));
         hi = 4'($urandom_range(0, 15));
         ofs = 4'($urandom_range(0, 15));
         start_hi = k[0];
         tag = (k % 3 == 0) ? "R2" : ((k % 3 == 1) ? "R3" : "R6");
         if (k == 0) begin lo = 4'd0; hi = 4'd15; end
         if (k == 1) begin lo = 4'd15; hi = 4'd0; end
         tag = "R4";
         do_sync(3);
         tag = (k % 2 == 0) ? "R5" : "R6";
         step(int'(ofs) + 4);
         tag = (k % 2 == 0) ? "R2" : "R3";
         step(70);
      end

      // count changes in the middle of a phase
      tag = "R7";
      lo = 4'd5; hi = 4'd3; ofs = 4'd0; start_hi = 1'b0;
      do_sync(1);
      step(2);
      lo = 4'd1; hi = 4'd9;
      step(30);
      hi = 4'd2;
      step(3);
      lo = 4'd12;
      step(40);

      // detached: static level, sync ignored, counter keeps going
      tag = "R9";
      lo = 4'd4; hi = 4'd6;
      ign = 1'b1; force_hi = 1'b1;
      step(10);
      tag = "R8";
      do_sync(4);
      step(5);
      force_hi = 1'b0;
      tag = "R9";
      step(6);
      do_sync(2);
      ign = 1'b0;
      tag = "R8";
      step(40);

      // force bit with sync obeyed
      tag = "R11";
      force_hi = 1'b1;
      step(30);
      force_hi = 1'b0;
      step(10);

      // bypass: clock passes through, divider frozen then resumes
      tag = "R10";
      byp = 1'b1;
      step(9);
      do_sync(2);
      step(3);
      byp = 1'b0;
      step(40);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule